// File: doc/BRIEF.md
# Variable-Width CRC-32 Update Unit

This block advances a 32-bit CRC accumulator by one data word of 1, 2, 4 or 8 bytes. A mode input selects the polynomial: the common CRC-32 (Ethernet/zip style) or the Castagnoli CRC-32C. The unit takes the current accumulator, a 64-bit word, a 2-bit size code and a start strobe. It returns the updated CRC, inverted and sign-extended to 64 bits, together with a one-cycle done strobe. An execution pipeline uses it to run a CRC update operation. Software chains operations by feeding each result back in as the next accumulator.

A build parameter picks one of two cores. The byte-serial core consumes one byte per clock. The parallel core unrolls every byte and answers one cycle after start. Both cores share a preparation stage. That stage masks the unused bytes and applies the mode-dependent pre-inversion to the accumulator.

Top module: `crc32_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, `done_o` is 0 and `result_o` is 0.
- R2: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 data bytes. Data bits at or above 8×bytes are ignored, so their value does not change the result.
- R3: Bytes enter the CRC least significant first. Byte 0 is `data_i[7:0]`, byte 1 is `data_i[15:8]`, and so on.
- R4: With `castagnoli_i` = 0, the CRC uses the reflected polynomial 0xEDB88320, shifting LSB first. The incoming accumulator is XORed with 0xFFFFFFFF before any byte is processed.
- R5: With `castagnoli_i` = 1, the CRC uses the reflected polynomial 0x82F63B78, shifting LSB first. The incoming accumulator is used as the starting state without inversion.
- R6: In both modes the final 32-bit CRC is XORed with 0xFFFFFFFF. Bits 63:32 of `result_o` are copies of bit 31.
- R7: In the serial build (SERIAL = 1), `done_o` is high for exactly one cycle, in the cycle after the Nth rising edge following the edge that sampled start, where N is the byte count. `result_o` holds its value until the next completion.
- R8: In the serial build, a start raised while an operation is in progress is ignored. The running operation's result and timing are unchanged, and no extra completion follows.
- R9: In the parallel build (SERIAL = 0), every sampled start yields `done_o` and the result in the cycle right after that edge.
- R10: Feeding the ASCII string "123456789" one byte at a time gives the standard check values. In CRC-32 mode, start with accumulator 0 and feed back each result; the final value is 0xCBF43926. In CRC-32C mode, start with 0xFFFFFFFF and feed back each inverted result; the final value is 0xE3069283.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start an update with the operands presented in this cycle |
| castagnoli_i | input | 1 | 0 = CRC-32, 1 = CRC-32C |
| size_i | input | 2 | Byte-count code: 0→1, 1→2, 2→4, 3→8 |
| acc_i | input | ACC_W | Incoming CRC accumulator |
| data_i | input | 8×DATA_BYTES | Data word, byte 0 in the low bits |
| result_o | output | RES_W | Inverted, sign-extended updated CRC |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The checker assumes that operands matter only in the cycle where start is sampled while the serial core is idle. It also assumes the size code always decodes to a count between one and eight, so an accepted start always leaves a nonzero byte count. The stimulus holds start for a single cycle per operation. It sweeps every size code in both modes, with random accumulators and random garbage in the masked upper bytes. In the serial build it deliberately raises a second start only while a run is in flight, to show that the second start is ignored.

// File: rtl/crc_pkg.sv
package crc_pkg;
   localparam int unsigned CRC_W    = 32;
   localparam logic [31:0] POLY_STD = 32'hEDB88320;
   localparam logic [31:0] POLY_CAS = 32'h82F63B78;
   localparam logic [31:0] CRC_ONES = 32'hFFFFFFFF;

   typedef enum logic [1:0] {
      SZ_ONE   = 2'd0,
      SZ_TWO   = 2'd1,
      SZ_FOUR  = 2'd2,
      SZ_EIGHT = 2'd3
   } size_code_e;

   typedef enum logic {
      MODE_STD = 1'b0,
      MODE_CAS = 1'b1
   } crc_mode_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int unsigned W      = 32,
   parameter logic [W-1:0] POLY_A = '0,
   parameter logic [W-1:0] POLY_B = '0
) (
   input  logic [W-1:0] crc_i,
   input  logic [7:0]   byte_i,
   input  logic         sel_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] poly;
   logic [W-1:0] stage [0:8];

   assign poly     = sel_i ? POLY_B : POLY_A;
   assign stage[0] = crc_i;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb           = stage[b][0] ^ byte_i[b];
      assign stage[b + 1] = (stage[b] >> 1) ^ (poly & {W{fb}});
   end

   assign crc_o = stage[8];
endmodule

// File: rtl/crc_prep.sv
module crc_prep
   import crc_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned NB = 8,
   parameter int unsigned CW = 4
) (
   input  logic [W-1:0]    acc_i,
   input  logic [8*NB-1:0] data_i,
   input  logic [1:0]      size_i,
   input  logic            cas_i,
   output logic [W-1:0]    seed_o,
   output logic [8*NB-1:0] data_o,
   output logic [CW-1:0]   nbytes_o
);
   always_comb begin
      unique case (size_code_e'(size_i))
         SZ_ONE:   nbytes_o = CW'(1);
         SZ_TWO:   nbytes_o = CW'(2);
         SZ_FOUR:  nbytes_o = CW'(4);
         default:  nbytes_o = CW'(8);
      endcase
   end

   assign seed_o = (crc_mode_e'(cas_i) == MODE_CAS) ? acc_i : ~acc_i;

   for (genvar k = 0; k < NB; k++) begin : g_mask
      assign data_o[8*k +: 8] = (CW'(k) < nbytes_o) ? data_i[8*k +: 8] : 8'h00;
   end
endmodule

// File: rtl/crc_serial_core.sv
module crc_serial_core
   import crc_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned NB = 8,
   parameter int unsigned RW = 64,
   parameter int unsigned CW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            cas_i,
   input  logic [W-1:0]    seed_i,
   input  logic [8*NB-1:0] data_i,
   input  logic [CW-1:0]   nbytes_i,
   output logic [RW-1:0]   result_o,
   output logic            done_o,
   output logic            busy_o,
   output logic [CW-1:0]   cnt_o
);
   logic            busy_q;
   logic            done_q;
   logic            cas_q;
   logic [CW-1:0]   cnt_q;
   logic [W-1:0]    crc_q;
   logic [8*NB-1:0] sh_q;
   logic [RW-1:0]   res_q;
   logic [W-1:0]    nxt;
   logic [W-1:0]    fin;

   crc_byte_step #(
      .W(W), .POLY_A(POLY_STD), .POLY_B(POLY_CAS)
   ) u_step (
      .crc_i (crc_q),
      .byte_i(sh_q[7:0]),
      .sel_i (cas_q),
      .crc_o (nxt)
   );

   assign fin = nxt ^ CRC_ONES;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cas_q  <= 1'b0;
         cnt_q  <= '0;
         crc_q  <= '0;
         sh_q   <= '0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               cnt_q  <= nbytes_i;
               crc_q  <= seed_i;
               sh_q   <= data_i;
               cas_q  <= cas_i;
            end
         end else begin
            crc_q <= nxt;
            sh_q  <= sh_q >> 8;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= {{(RW-W){fin[W-1]}}, fin};
            end
         end
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;
   assign busy_o   = busy_q;
   assign cnt_o    = cnt_q;
endmodule

// File: rtl/crc_parallel_core.sv
module crc_parallel_core
   import crc_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned NB = 8,
   parameter int unsigned RW = 64,
   parameter int unsigned CW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            cas_i,
   input  logic [W-1:0]    seed_i,
   input  logic [8*NB-1:0] data_i,
   input  logic [CW-1:0]   nbytes_i,
   output logic [RW-1:0]   result_o,
   output logic            done_o,
   output logic            busy_o,
   output logic [CW-1:0]   cnt_o
);
   logic [W-1:0]  chain [0:NB];
   logic [W-1:0]  pick;
   logic [W-1:0]  fin;
   logic [RW-1:0] res_q;
   logic          done_q;

   assign chain[0] = seed_i;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      crc_byte_step #(
         .W(W), .POLY_A(POLY_STD), .POLY_B(POLY_CAS)
      ) u_step (
         .crc_i (chain[k]),
         .byte_i(data_i[8*k +: 8]),
         .sel_i (cas_i),
         .crc_o (chain[k + 1])
      );
   end

   always_comb begin
      pick = chain[1];
      for (int k = 1; k <= NB; k++) begin
         if (nbytes_i == CW'(k)) pick = chain[k];
      end
   end

   assign fin = pick ^ CRC_ONES;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= start_i;
         if (start_i) res_q <= {{(RW-W){fin[W-1]}}, fin};
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;
   assign busy_o   = 1'b0;
   assign cnt_o    = '0;
endmodule

// File: rtl/crc32_unit.sv
module crc32_unit #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned DATA_BYTES = 8,
   parameter int unsigned RES_W      = 64,
   parameter bit          SERIAL     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    castagnoli_i,
   input  logic [1:0]              size_i,
   input  logic [ACC_W-1:0]        acc_i,
   input  logic [8*DATA_BYTES-1:0] data_i,
   output logic [RES_W-1:0]        result_o,
   output logic                    done_o
);
   localparam int unsigned CNT_W = $clog2(DATA_BYTES + 1);

   if (ACC_W != crc_pkg::CRC_W) begin : g_bad_acc
      $error("crc32_unit: ACC_W must equal the CRC width");
   end
   if (DATA_BYTES != 8) begin : g_bad_bytes
      $error("crc32_unit: the 2-bit size code needs DATA_BYTES of 8");
   end
   if (RES_W <= ACC_W) begin : g_bad_res
      $error("crc32_unit: RES_W must exceed ACC_W for sign extension");
   end

   logic [ACC_W-1:0]        seed_w;
   logic [8*DATA_BYTES-1:0] data_w;
   logic [CNT_W-1:0]        nbytes_w;
   logic                    busy_w;
   logic [CNT_W-1:0]        cnt_w;

   crc_prep #(
      .W(ACC_W), .NB(DATA_BYTES), .CW(CNT_W)
   ) u_prep (
      .acc_i   (acc_i),
      .data_i  (data_i),
      .size_i  (size_i),
      .cas_i   (castagnoli_i),
      .seed_o  (seed_w),
      .data_o  (data_w),
      .nbytes_o(nbytes_w)
   );

   if (SERIAL) begin : g_serial
      crc_serial_core #(
         .W(ACC_W), .NB(DATA_BYTES), .RW(RES_W), .CW(CNT_W)
      ) u_core (
         .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas_i(castagnoli_i),
         .seed_i(seed_w), .data_i(data_w), .nbytes_i(nbytes_w),
         .result_o(result_o), .done_o(done_o), .busy_o(busy_w), .cnt_o(cnt_w)
      );
   end else begin : g_parallel
      crc_parallel_core #(
         .W(ACC_W), .NB(DATA_BYTES), .RW(RES_W), .CW(CNT_W)
      ) u_core (
         .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas_i(castagnoli_i),
         .seed_i(seed_w), .data_i(data_w), .nbytes_i(nbytes_w),
         .result_o(result_o), .done_o(done_o), .busy_o(busy_w), .cnt_o(cnt_w)
      );
   end
endmodule

// File: rtl/crc32_unit_chk.sv
module crc32_unit_chk #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned RES_W  = 64,
   parameter int unsigned NB     = 8,
   parameter int unsigned CNT_W  = 4,
   parameter bit          SERIAL = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             done_o,
   input logic [RES_W-1:0] result_o,
   input logic             busy,
   input logic [CNT_W-1:0] cnt
);
   // R6
   sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o[RES_W-1:ACC_W] == {(RES_W-ACC_W){result_o[ACC_W-1]}}));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   // R7
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SERIAL && start_i && !busy) |=> (busy && !done_o));

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SERIAL && busy) |=> (busy || done_o));

   // R8
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SERIAL && done_o) |-> !busy);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt != '0 && cnt <= CNT_W'(NB)));

   // R9
   par_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!SERIAL && start_i) |=> done_o);
endmodule

bind crc32_unit crc32_unit_chk #(
   .ACC_W(ACC_W), .RES_W(RES_W), .NB(DATA_BYTES), .CNT_W(CNT_W), .SERIAL(SERIAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
   .result_o(result_o), .busy(busy_w), .cnt(cnt_w)
);

// File: tb/crc32_unit_tb.sv
`timescale 1ns/1ps
module crc32_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_s = 1'b0;
   logic        start_p = 1'b0;
   logic        cas = 1'b0;
   logic [1:0]  size = 2'd0;
   logic [31:0] acc = '0;
   logic [63:0] data = '0;
   logic [63:0] res_s, res_p;
   logic        done_s, done_p;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          ended = 1'b0;

   always #10 clk = ~clk;

   crc32_unit #(.SERIAL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_s), .castagnoli_i(cas),
      .size_i(size), .acc_i(acc), .data_i(data), .result_o(res_s), .done_o(done_s));

   crc32_unit #(.SERIAL(1'b0)) u_par (
      .clk(clk), .rst_n(rst_n), .start_i(start_p), .castagnoli_i(cas),
      .size_i(size), .acc_i(acc), .data_i(data), .result_o(res_p), .done_o(done_p));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [31:0] a, input logic [63:0] d,
                                         input logic [1:0] sz, input bit c);
      logic [31:0] p;
      logic [31:0] s;
      int          nb;
      p  = c ? 32'h82F63B78 : 32'hEDB88320;
      s  = c ? a : (a ^ 32'hFFFFFFFF);
      nb = 1 << sz;
      for (int k = 0; k < nb; k++) begin
         s = s ^ {24'h0, d[8*k +: 8]};
         for (int j = 0; j < 8; j++) s = s[0] ? ((s >> 1) ^ p) : (s >> 1);
      end
      s = ~s;
      return {{32{s[31]}}, s};
   endfunction

   task automatic run_ser(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz,
                          input bit c, input bit poke, output logic [63:0] r);
      int nb;
      int early;
      nb    = 1 << sz;
      early = 0;
      @(negedge clk);
      acc = a; data = d; size = sz; cas = c; start_s = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_s = 1'b0;
      if (done_s) early++;
      if (poke) begin
         start_s = 1'b1; acc = ~a; data = ~d; cas = ~c; size = 2'd0;
      end
      for (int e = 1; e <= nb; e++) begin
         @(posedge clk);
         @(negedge clk);
         start_s = 1'b0;
         if (e < nb && done_s) early++;
      end
      chk("R7 done after N edges", {63'h0, done_s}, 64'd1);
      chk("R7 no early done", 64'(early), 64'd0);
      r = res_s;
   endtask

   task automatic run_par(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz,
                          input bit c, output logic [63:0] r);
      @(negedge clk);
      acc = a; data = d; size = sz; cas = c; start_p = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_p = 1'b0;
      chk("R9 done next cycle", {63'h0, done_p}, 64'd1);
      r = res_p;
      @(posedge clk);
      @(negedge clk);
      chk("R9 done single pulse", {63'h0, done_p}, 64'd0);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] r;
      logic [63:0] hold;
      logic [31:0] a;
      logic [63:0] d;
      string       s;
      int          stray;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 serial done in reset", {63'h0, done_s}, 64'd0);
      chk("R1 serial result in reset", res_s, 64'd0);
      chk("R1 parallel done in reset", {63'h0, done_p}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 serial result after reset", res_s, 64'd0);
      chk("R1 parallel result after reset", res_p, 64'd0);

      // R2 R4 R5 R6 sweep over modes and sizes, garbage in upper bytes
      for (int c = 0; c < 2; c++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int t = 0; t < 6; t++) begin
               a = (t == 0) ? 32'h0 : (t == 1) ? 32'hFFFFFFFF : $urandom;
               d = {$urandom, $urandom};
               run_ser(a, d, 2'(sz), c[0], 1'b0, r);
               chk(c ? "R5 R2 R6 serial crc32c" : "R4 R2 R6 serial crc32", r,
                   model(a, d, 2'(sz), c[0]));
               run_par(a, d, 2'(sz), c[0], r);
               chk(c ? "R5 R2 R6 parallel crc32c" : "R4 R2 R6 parallel crc32", r,
                   model(a, d, 2'(sz), c[0]));
            end
         end
      end

      // R2 masked bytes have no effect
      run_ser(32'h1234_5678, 64'hFFFF_FFFF_FFFF_0041, 2'd1, 1'b0, 1'b0, r);
      hold = r;
      run_ser(32'h1234_5678, 64'h0000_0000_0000_0041, 2'd1, 1'b0, 1'b0, r);
      chk("R2 upper bytes ignored", r, hold);

      // R3 little-endian byte order
      run_ser(32'h0, 64'h3837363534333231, 2'd3, 1'b0, 1'b0, r);
      run_ser(r[31:0], 64'hDEAD_BEEF_CAFE_5A39, 2'd0, 1'b0, 1'b0, r);
      chk("R3 serial LSB-first", r, 64'hFFFF_FFFF_CBF4_3926);
      run_par(32'h0, 64'h3837363534333231, 2'd3, 1'b0, r);
      run_par(r[31:0], 64'h0000_0000_0000_0039, 2'd0, 1'b0, r);
      chk("R3 parallel LSB-first", r, 64'hFFFF_FFFF_CBF4_3926);

      // R10 check values, one byte at a time
      s = "123456789";
      a = 32'h0;
      for (int i = 0; i < 9; i++) begin
         run_ser(a, {56'h0, s[i]}, 2'd0, 1'b0, 1'b0, r);
         a = r[31:0];
      end
      chk("R10 crc32 check value", r, 64'hFFFF_FFFF_CBF4_3926);
      a = 32'hFFFFFFFF;
      for (int i = 0; i < 9; i++) begin
         run_ser(a, {56'h0, s[i]}, 2'd0, 1'b1, 1'b0, r);
         a = ~r[31:0];
      end
      chk("R10 crc32c check value", r, 64'hFFFF_FFFF_E306_9283);

      // R8 start during busy is ignored
      for (int sz = 0; sz < 4; sz++) begin
         a = $urandom;
         d = {$urandom, $urandom};
         run_ser(a, d, 2'(sz), 1'b1, 1'b1, r);
         chk("R8 busy start ignored, result", r, model(a, d, 2'(sz), 1'b1));
         stray = 0;
         for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done_s) stray++;
         end
         chk("R8 no extra completion", 64'(stray), 64'd0);
         chk("R7 result held", res_s, r);
      end

      finish_run();
   end
endmodule